// File: doc/BRIEF.md
# Scan-Accessed Debug Register File

This block is a small bank of debug registers that an external debugger reaches through a 38-bit serial data register. The scan path follows the usual test-port data-register phases: capture, shift and update. Each scan word has three fields: a direction flag in bit 37 (1 = write, 0 = read), a 5-bit register address in bits 36:32, and a 32-bit data field in bits 31:0. Words shift in at the most significant end and leave at bit 0 on `tdo`.

A read takes two scans. The update phase of the first scan points the capture pointer at the chosen register. The capture phase of the next scan loads that register into the data field. The bank holds four registers: a debug control register, a read-only debug status register, a channel control register and a channel data register. The two channel registers form a one-word mailbox in each direction between the debugger and the core. The core has a plain write and read port with two flags. The scan side runs on `tck` and the core side on `sys_clk`. The flags cross between the clocks through synchroniser chains, and the data words are held stable while a flag is set.

Top module: `dbgscan_regfile`

## Requirements
- R1: After reset, `dbg_ctrl` is 0, `core_tx_full` and `core_rx_valid` are 0, and the capture pointer selects channel control (address 4). The first scan after reset therefore captures the channel control word.
- R2: The scan word is 38 bits: data in 31:0, address in 36:32, and the direction flag in bit 37 (1 = write). Shift moves `tdi` into bit 37 and presents bit 0 on `tdo`. Capture loads only bits 31:0 and leaves bits 37:32 unchanged.
- R3: The update of a read scan latches its address into the capture pointer, and the next capture returns that register. The update of a write scan sets the capture pointer to channel control (address 4).
- R4: Channel control (address 4) captures as follows. Bits 31:28 hold the VERSION parameter. Bit 1 is the core-to-debugger pending flag, bit 0 is the debugger-to-core pending flag, and all other bits are 0. Capturing it changes no state.
- R5: Debug control (address 0) is a CTRL_W-bit read/write register, driven out on `dbg_ctrl`. Bit 4 is the monitor-mode enable, and writing it to 0 selects halting debug. Bits above CTRL_W-1 read as 0.
- R6: Debug status (address 1) captures `dbg_status`, zero-extended. Write scans to it have no effect.
- R7: Addresses other than 0, 1, 4 and 5 capture as 0, and write scans to them change no register.
- R8: A `core_wr` pulse while `core_tx_full` is 0 stores `core_wdata` and sets `core_tx_full` and channel control bit 1. A `core_wr` while `core_tx_full` is 1 is ignored.
- R9: A capture with the pointer at channel data (address 5) returns the core word and clears channel control bit 1. `core_tx_full` falls after synchronisation. Such a capture with nothing pending changes no flag.
- R10: A write scan to address 5 while channel control bit 0 is clear sets bit 0, and after synchronisation raises `core_rx_valid` with the word on `core_rdata`. Write scans may follow one another with no polling. A write to address 5 while bit 0 is set is dropped.
- R11: A `core_rd` pulse while `core_rx_valid` is 1 clears `core_rx_valid` at once, and channel control bit 0 clears after synchronisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| tck_rst | input | 1 | Synchronous active-high reset, scan side |
| capture_dr | input | 1 | Capture phase strobe |
| shift_dr | input | 1 | Shift phase strobe |
| update_dr | input | 1 | Update phase strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (scan bit 0) |
| sys_clk | input | 1 | Core clock |
| sys_rst | input | 1 | Synchronous active-high reset, core side |
| core_wr | input | 1 | Core pushes a word to the debugger |
| core_wdata | input | 32 | Word pushed by the core |
| core_tx_full | output | 1 | Core-to-debugger word still pending |
| core_rd | input | 1 | Core takes the debugger's word |
| core_rdata | output | 32 | Word written by the debugger |
| core_rx_valid | output | 1 | Debugger-to-core word available |
| dbg_status | input | STAT_W | Status bits shown at address 1 |
| dbg_ctrl | output | CTRL_W | Debug control register contents |

## Verification
The bench builds the block with VERSION = 9, so a constant version field cannot pass by chance as zero, and with SYNC_STAGES = 3, so the flag handshake works through a deeper chain than the default of 2. The core clock runs four times faster than the scan clock. This lets the bench observe the delayed flag drops on both sides, a pop with nothing pending, a core write while full, and a debugger write that lands while the previous word is still unread.

// File: rtl/dbgscan_pkg.sv
`timescale 1ns/1ps
package dbgscan_pkg;

    localparam int SCAN_DATA_W = 32;
    localparam int SCAN_ADDR_W = 5;
    localparam int SCAN_LEN    = SCAN_DATA_W + SCAN_ADDR_W + 1;
    localparam int VER_W       = 4;

    // Bit positions inside the channel control word
    localparam int CHAN_RX_BIT = 0;
    localparam int CHAN_TX_BIT = 1;

    typedef struct packed {
        logic                   wr;
        logic [SCAN_ADDR_W-1:0] addr;
        logic [SCAN_DATA_W-1:0] data;
    } scan_word_t;

    typedef enum logic [SCAN_ADDR_W-1:0] {
        REG_DBG_CTRL  = 5'd0,
        REG_DBG_STAT  = 5'd1,
        REG_CHAN_CTRL = 5'd4,
        REG_CHAN_DATA = 5'd5
    } reg_addr_e;

    function automatic logic [SCAN_DATA_W-1:0] chan_ctrl_word(
        input logic [VER_W-1:0] ver,
        input logic             tx_pend,
        input logic             rx_pend
    );
        logic [SCAN_DATA_W-1:0] w;
        w = '0;
        w[SCAN_DATA_W-1 -: VER_W] = ver;
        w[CHAN_TX_BIT]            = tx_pend;
        w[CHAN_RX_BIT]            = rx_pend;
        return w;
    endfunction

endpackage

// File: rtl/dbgscan_sync.sv
`timescale 1ns/1ps
module dbgscan_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dbgscan_shifter.sv
`timescale 1ns/1ps
module dbgscan_shifter
    import dbgscan_pkg::*;
(
    input  logic                   tck,
    input  logic                   rst,
    input  logic                   capture_en,
    input  logic                   shift_en,
    input  logic                   tdi,
    input  logic [SCAN_DATA_W-1:0] cap_data,
    output scan_word_t             sr_q,
    output logic                   tdo
);
    always_ff @(posedge tck) begin
        if (rst) begin
            sr_q <= '0;
        end else if (capture_en) begin
            sr_q.data <= cap_data;
        end else if (shift_en) begin
            sr_q <= {tdi, sr_q[SCAN_LEN-1:1]};
        end
    end

    assign tdo = sr_q[0];
endmodule

// File: rtl/dbgscan_chan.sv
`timescale 1ns/1ps
module dbgscan_chan
    import dbgscan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   tck,
    input  logic                   tck_rst,
    input  logic                   sys_clk,
    input  logic                   sys_rst,
    // scan side
    input  logic                   pop_req,
    input  logic                   push_req,
    input  logic [SCAN_DATA_W-1:0] push_data,
    output logic                   tx_pend,
    output logic                   rx_pend,
    output logic [SCAN_DATA_W-1:0] tx_word,
    // core side
    input  logic                   core_wr,
    input  logic [SCAN_DATA_W-1:0] core_wdata,
    input  logic                   core_rd,
    output logic                   core_tx_full,
    output logic                   core_rx_valid,
    output logic [SCAN_DATA_W-1:0] core_rdata
);
    // core -> debugger
    logic                   tx_req_t, tx_ack_t, tx_req_k, tx_ack_s;
    logic [SCAN_DATA_W-1:0] tx_data_q;
    // debugger -> core
    logic                   rx_req_t, rx_ack_t, rx_req_s, rx_ack_k;
    logic [SCAN_DATA_W-1:0] rx_data_q;

    dbgscan_sync #(.W(1), .STAGES(SYNC_STAGES)) u_tx_req_sync (
        .clk(tck), .rst(tck_rst), .d(tx_req_t), .q(tx_req_k));
    dbgscan_sync #(.W(1), .STAGES(SYNC_STAGES)) u_tx_ack_sync (
        .clk(sys_clk), .rst(sys_rst), .d(tx_ack_t), .q(tx_ack_s));
    dbgscan_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rx_req_sync (
        .clk(sys_clk), .rst(sys_rst), .d(rx_req_t), .q(rx_req_s));
    dbgscan_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rx_ack_sync (
        .clk(tck), .rst(tck_rst), .d(rx_ack_t), .q(rx_ack_k));

    assign core_tx_full  = tx_req_t ^ tx_ack_s;
    assign tx_pend       = tx_req_k ^ tx_ack_t;
    assign rx_pend       = rx_req_t ^ rx_ack_k;
    assign core_rx_valid = rx_req_s ^ rx_ack_t;
    assign tx_word       = tx_data_q;
    assign core_rdata    = rx_data_q;

    // core clock domain
    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            tx_req_t  <= 1'b0;
            tx_data_q <= '0;
            rx_ack_t  <= 1'b0;
        end else begin
            if (core_wr && !core_tx_full) begin
                tx_data_q <= core_wdata;
                tx_req_t  <= ~tx_req_t;
            end
            if (core_rd && core_rx_valid) begin
                rx_ack_t <= ~rx_ack_t;
            end
        end
    end

    // scan clock domain
    always_ff @(posedge tck) begin
        if (tck_rst) begin
            tx_ack_t  <= 1'b0;
            rx_req_t  <= 1'b0;
            rx_data_q <= '0;
        end else begin
            if (pop_req && tx_pend) begin
                tx_ack_t <= ~tx_ack_t;
            end
            if (push_req && !rx_pend) begin
                rx_data_q <= push_data;
                rx_req_t  <= ~rx_req_t;
            end
        end
    end
endmodule

// File: rtl/dbgscan_regfile.sv
`timescale 1ns/1ps
module dbgscan_regfile
    import dbgscan_pkg::*;
#(
    parameter logic [3:0] VERSION     = 4'h6,
    parameter int         CTRL_W      = 6,
    parameter int         STAT_W      = 5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   tck,
    input  logic                   tck_rst,
    input  logic                   capture_dr,
    input  logic                   shift_dr,
    input  logic                   update_dr,
    input  logic                   tdi,
    output logic                   tdo,
    input  logic                   sys_clk,
    input  logic                   sys_rst,
    input  logic                   core_wr,
    input  logic [SCAN_DATA_W-1:0] core_wdata,
    output logic                   core_tx_full,
    input  logic                   core_rd,
    output logic [SCAN_DATA_W-1:0] core_rdata,
    output logic                   core_rx_valid,
    input  logic [STAT_W-1:0]      dbg_status,
    output logic [CTRL_W-1:0]      dbg_ctrl
);
    scan_word_t             sr_q;
    logic [SCAN_ADDR_W-1:0] cap_ptr_q;
    logic [CTRL_W-1:0]      ctrl_q;
    logic [STAT_W-1:0]      stat_k;
    logic [SCAN_DATA_W-1:0] cap_data;
    logic [SCAN_DATA_W-1:0] tx_word;
    logic                   tx_pend, rx_pend;
    logic                   pop_req, push_req;
    logic                   upd_wr, upd_rd;

    dbgscan_shifter u_shift (
        .tck        (tck),
        .rst        (tck_rst),
        .capture_en (capture_dr),
        .shift_en   (shift_dr),
        .tdi        (tdi),
        .cap_data   (cap_data),
        .sr_q       (sr_q),
        .tdo        (tdo)
    );

    dbgscan_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_stat_sync (
        .clk(tck), .rst(tck_rst), .d(dbg_status), .q(stat_k));

    // capture mux selected by the pointer left by the previous update
    always_comb begin
        case (cap_ptr_q)
            REG_DBG_CTRL:  cap_data = SCAN_DATA_W'(ctrl_q);
            REG_DBG_STAT:  cap_data = SCAN_DATA_W'(stat_k);
            REG_CHAN_CTRL: cap_data = chan_ctrl_word(VERSION, tx_pend, rx_pend);
            REG_CHAN_DATA: cap_data = tx_word;
            default:       cap_data = '0;
        endcase
    end

    assign pop_req  = capture_dr && (cap_ptr_q == REG_CHAN_DATA);
    assign upd_wr   = update_dr && sr_q.wr;
    assign upd_rd   = update_dr && !sr_q.wr;
    assign push_req = upd_wr && (sr_q.addr == REG_CHAN_DATA);

    // update decode
    always_ff @(posedge tck) begin
        if (tck_rst) begin
            cap_ptr_q <= REG_CHAN_CTRL;
            ctrl_q    <= '0;
        end else begin
            if (upd_rd) begin
                cap_ptr_q <= sr_q.addr;
            end else if (upd_wr) begin
                cap_ptr_q <= REG_CHAN_CTRL;
                if (sr_q.addr == REG_DBG_CTRL) begin
                    ctrl_q <= sr_q.data[CTRL_W-1:0];
                end
            end
        end
    end

    assign dbg_ctrl = ctrl_q;

    dbgscan_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
        .tck           (tck),
        .tck_rst       (tck_rst),
        .sys_clk       (sys_clk),
        .sys_rst       (sys_rst),
        .pop_req       (pop_req),
        .push_req      (push_req),
        .push_data     (sr_q.data),
        .tx_pend       (tx_pend),
        .rx_pend       (rx_pend),
        .tx_word       (tx_word),
        .core_wr       (core_wr),
        .core_wdata    (core_wdata),
        .core_rd       (core_rd),
        .core_tx_full  (core_tx_full),
        .core_rx_valid (core_rx_valid),
        .core_rdata    (core_rdata)
    );
endmodule

// File: rtl/dbgscan_checker.sv
`timescale 1ns/1ps
module dbgscan_checker #(
    parameter int CTRL_W = 6
) (
    input logic              tck,
    input logic              tck_rst,
    input logic              sys_clk,
    input logic              sys_rst,
    input logic              capture_dr,
    input logic              shift_dr,
    input logic              update_dr,
    input logic              tdi,
    input logic [37:0]       sr,
    input logic [CTRL_W-1:0] dbg_ctrl,
    input logic              core_wr,
    input logic              core_rd,
    input logic              core_tx_full,
    input logic              core_rx_valid,
    input logic [31:0]       core_rdata
);
    AST_SHIFT_MOVES: assert property (@(posedge tck) disable iff (tck_rst)
        (shift_dr && !capture_dr) |=> (sr == {$past(tdi), $past(sr[37:1])})); // R2

    AST_CAPTURE_KEEPS_HEADER: assert property (@(posedge tck) disable iff (tck_rst)
        capture_dr |=> $stable(sr[37:32])); // R2

    AST_CTRL_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (tck_rst)
        !update_dr |=> $stable(dbg_ctrl)); // R5

    AST_TX_SETS_FULL: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (core_wr && !core_tx_full) |=> core_tx_full); // R8

    AST_RX_HOLDS: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (core_rx_valid && !core_rd) |=> (core_rx_valid && $stable(core_rdata))); // R10

    AST_RX_CONSUMED: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (core_rx_valid && core_rd) |=> !core_rx_valid); // R11
endmodule

bind dbgscan_regfile dbgscan_checker #(.CTRL_W(CTRL_W)) u_dbgscan_checker (
    .tck           (tck),
    .tck_rst       (tck_rst),
    .sys_clk       (sys_clk),
    .sys_rst       (sys_rst),
    .capture_dr    (capture_dr),
    .shift_dr      (shift_dr),
    .update_dr     (update_dr),
    .tdi           (tdi),
    .sr            (sr_q),
    .dbg_ctrl      (dbg_ctrl),
    .core_wr       (core_wr),
    .core_rd       (core_rd),
    .core_tx_full  (core_tx_full),
    .core_rx_valid (core_rx_valid),
    .core_rdata    (core_rdata)
);

// File: tb/test_dbgscan_regfile.sv
`timescale 1ns/1ps
module test_dbgscan_regfile;
    localparam logic [3:0]  VER  = 4'h9;
    localparam int          SYNC = 3;
    localparam logic [31:0] CV   = 32'h9000_0000; // channel control, no flag set

    logic        tck = 1'b0, sys_clk = 1'b0;
    logic        tck_rst = 1'b1, sys_rst = 1'b1;
    logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic        core_wr = 1'b0, core_rd = 1'b0;
    logic [31:0] core_wdata = '0;
    logic        core_tx_full, core_rx_valid;
    logic [31:0] core_rdata;
    logic [4:0]  dbg_status = '0;
    logic [5:0]  dbg_ctrl;

    always #2.5 sys_clk = ~sys_clk;   // 200 MHz
    always #10  tck     = ~tck;

    dbgscan_regfile #(.VERSION(VER), .SYNC_STAGES(SYNC)) i_dbgscan_regfile (
        .tck(tck), .tck_rst(tck_rst), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .sys_clk(sys_clk), .sys_rst(sys_rst),
        .core_wr(core_wr), .core_wdata(core_wdata), .core_tx_full(core_tx_full),
        .core_rd(core_rd), .core_rdata(core_rdata), .core_rx_valid(core_rx_valid),
        .dbg_status(dbg_status), .dbg_ctrl(dbg_ctrl));

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic [31:0] v;
        string       tag;
    } item_t;
    item_t       exp_q[$];
    logic [31:0] got_q[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compare captured words against the expectations in order
    initial forever begin
        @(negedge tck);
        while (got_q.size() > 0) begin
            logic [31:0] g;
            g = got_q.pop_front();
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R3 unexpected capture: actual %h expected none", g);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(e.tag, g, e.v);
            end
        end
    end

    // one complete scan; the captured data field is pushed when chk is set
    task automatic scan(bit wr, logic [4:0] a, logic [31:0] d, bit chk);
        logic [37:0] outw;
        logic [31:0] cap;
        outw = {wr, a, d};
        cap  = '0;
        @(negedge tck) capture_dr = 1'b1;
        @(negedge tck) begin capture_dr = 1'b0; shift_dr = 1'b1; end
        for (int i = 0; i < 38; i++) begin
            if (i < 32) cap[i] = tdo;
            tdi = outw[i];
            @(negedge tck);
        end
        shift_dr  = 1'b0;
        update_dr = 1'b1;
        @(negedge tck) update_dr = 1'b0;
        if (chk) got_q.push_back(cap);
    endtask

    task automatic expect_cap(logic [31:0] v, string tag);
        item_t e;
        e.v = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // two-scan read, leaving the pointer on channel control
    task automatic read_reg(logic [4:0] a, logic [31:0] v, string tag);
        scan(1'b0, a, 32'h0, 1'b0);
        expect_cap(v, tag);
        scan(1'b0, 5'd4, 32'h0, 1'b1);
    endtask

    task automatic core_write(logic [31:0] d);
        @(negedge sys_clk) begin core_wr = 1'b1; core_wdata = d; end
        @(negedge sys_clk) core_wr = 1'b0;
    endtask

    task automatic core_read(output logic [31:0] d);
        @(negedge sys_clk) begin d = core_rdata; core_rd = 1'b1; end
        @(negedge sys_clk) core_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge tck);
    endtask

    task automatic run_tests();
        logic [31:0] rd;
        repeat (5) @(negedge tck);
        tck_rst = 1'b0; sys_rst = 1'b0;
        @(negedge tck);
        // R1 reset state
        check("R1 dbg_ctrl", 32'(dbg_ctrl), 32'h0);
        check("R1 core_tx_full", 32'(core_tx_full), 32'h0);
        check("R1 core_rx_valid", 32'(core_rx_valid), 32'h0);
        expect_cap(CV, "R1 first capture is channel control");
        scan(1'b0, 5'd4, 32'h0, 1'b1);
        // R4 / R2 version field and framing
        read_reg(5'd4, CV, "R4 channel control word");
        // R5 debug control
        scan(1'b1, 5'd0, 32'hFFFF_FFFF, 1'b0);
        check("R5 dbg_ctrl all ones", 32'(dbg_ctrl), 32'h3F);
        read_reg(5'd0, 32'h3F, "R5 upper bits read zero");
        scan(1'b1, 5'd0, 32'h0000_002F, 1'b0);
        check("R5 monitor bit cleared", 32'(dbg_ctrl[4]), 32'h0);
        read_reg(5'd0, 32'h2F, "R5 readback");
        // R3 write scan leaves pointer on channel control
        scan(1'b1, 5'd0, 32'h0000_0021, 1'b0);
        expect_cap(CV, "R3 pointer after write");
        scan(1'b0, 5'd4, 32'h0, 1'b1);
        // R6 status
        dbg_status = 5'h15;
        settle();
        read_reg(5'd1, 32'h15, "R6 status read");
        scan(1'b1, 5'd1, 32'hFFFF_FFFF, 1'b0);
        read_reg(5'd1, 32'h15, "R6 status write ignored");
        read_reg(5'd0, 32'h21, "R6 ctrl untouched");
        // R7 unmapped
        read_reg(5'd7, 32'h0, "R7 addr 7 reads zero");
        read_reg(5'd31, 32'h0, "R7 addr 31 reads zero");
        scan(1'b1, 5'd7, 32'hFFFF_FFFF, 1'b0);
        read_reg(5'd0, 32'h21, "R7 write ignored");
        read_reg(5'd4, CV, "R7 no flag set");
        // R8 core to debugger
        core_write(32'hCAFE_F00D);
        check("R8 core_tx_full set", 32'(core_tx_full), 32'h1);
        settle();
        read_reg(5'd4, CV | 32'h2, "R8 pending flag");
        core_write(32'h1111_1111);
        check("R8 still full", 32'(core_tx_full), 32'h1);
        read_reg(5'd4, CV | 32'h2, "R4 capture has no side effect");
        // R9 pop
        scan(1'b0, 5'd5, 32'h0, 1'b0);
        expect_cap(32'hCAFE_F00D, "R9 popped word");
        scan(1'b0, 5'd4, 32'h0, 1'b1);
        expect_cap(CV, "R9 flag cleared");
        scan(1'b0, 5'd4, 32'h0, 1'b1);
        settle();
        check("R9 core_tx_full cleared", 32'(core_tx_full), 32'h0);
        scan(1'b0, 5'd5, 32'h0, 1'b0);
        scan(1'b0, 5'd4, 32'h0, 1'b0);
        settle();
        check("R9 empty pop no effect", 32'(core_tx_full), 32'h0);
        core_write(32'h0BAD_BEEF);
        settle();
        scan(1'b0, 5'd5, 32'h0, 1'b0);
        expect_cap(32'h0BAD_BEEF, "R9 second word");
        scan(1'b0, 5'd4, 32'h0, 1'b1);
        settle();
        // R10 debugger to core
        scan(1'b1, 5'd5, 32'h1234_5678, 1'b0);
        settle();
        check("R10 core_rx_valid", 32'(core_rx_valid), 32'h1);
        check("R10 core_rdata", core_rdata, 32'h1234_5678);
        read_reg(5'd4, CV | 32'h1, "R10 rx flag");
        scan(1'b1, 5'd5, 32'h8765_4321, 1'b0);
        settle();
        check("R10 write while pending dropped", core_rdata, 32'h1234_5678);
        // R11 core consumes
        core_read(rd);
        check("R11 read data", rd, 32'h1234_5678);
        check("R11 valid cleared", 32'(core_rx_valid), 32'h0);
        settle();
        read_reg(5'd4, CV, "R11 rx flag cleared");
        // R10 back-to-back write scans
        scan(1'b1, 5'd5, 32'hA5A5_A5A5, 1'b0);
        scan(1'b1, 5'd0, 32'h0000_0003, 1'b0);
        settle();
        check("R10 back-to-back data", core_rdata, 32'hA5A5_A5A5);
        check("R10 back-to-back ctrl", 32'(dbg_ctrl), 32'h3);
        core_read(rd);
        repeat (10) @(negedge tck);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R3 missing captures: actual %0d left expected 0", exp_q.size());
        end
    endtask

    initial begin
        fork
            run_tests();
            begin
                #1000000;
                n_chk++; n_fail++;
                $display("FAIL watchdog (all requirements): actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule